// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the memory-mapped register front end of a platform interrupt controller. It takes single-cycle 32-bit read and write requests, each carrying a byte offset, and decodes them into four windows. Each window has its own parameterised base: per-source priority, the read-only pending bitmap, per-context enable bitmaps, and per-context threshold and claim/complete registers. The priority, threshold and enable registers live here and are exported as flat vectors for the arbiter. Claim reads and complete writes become one-cycle strobes toward the arbiter, and a claim read returns the arbiter's current best id for that context.

Priority and threshold writes are filtered to legal values. If the largest priority plus one is a power of two, the stored value is the written value modulo that count. Otherwise a write above the largest priority is dropped and the old value stays. The enable and context windows are divided into fixed-size slots per context, and the slot sizes must be powers of two.

Top module: `irqc_reg_frontend`

## Requirements
- R1: After reset, all priority, threshold and enable registers are zero, the claim and complete strobes are low, and the read response is zero and not valid.
- R2: A read request yields `rsp_valid` high with its data in the next cycle. A write request never raises `rsp_valid`.
- R3: The priority window gives each source 4 bytes. Source index = (address − priority base) >> 2. Reads return the stored priority, zero-extended.
- R4: When MAX_PRIO+1 is a power of two, a priority or threshold write stores the written value modulo (MAX_PRIO+1).
- R5: When MAX_PRIO+1 is not a power of two, a priority or threshold write above MAX_PRIO is dropped and the previous value stays. A value up to MAX_PRIO is stored as written.
- R6: The pending window spans (NUM_SRC+31)>>3 bytes. Word w, at offset 4·w, returns pending_in bits 32·w+31 down to 32·w, with zero for bits of sources that do not exist. Writes to it change nothing.
- R7: In the enable window, context = offset / EN_STRIDE and word = (offset mod EN_STRIDE) >> 2. Bit b of word w enables source 32·w+b of that context. Bits of sources that do not exist are not stored and read as zero.
- R8: An enable word whose index is at or beyond ceil(NUM_SRC/32) ignores writes and reads as zero.
- R9: In the context window, context = offset / CTX_STRIDE. Offset 0 within a context slot is that context's threshold register, written under the same legal-value rule as priorities.
- R10: A read at offset 4 of a context slot returns that context's claim_id_in value. In the next cycle it raises only that context's claim_stb bit, for one cycle.
- R11: A write at offset 4 of a context slot with a value below NUM_SRC raises only that context's complete_stb bit for one cycle in the next cycle, with complete_id equal to the value. A value of NUM_SRC or more raises no strobe.
- R12: Addresses outside all windows, and context-slot offsets other than 0 and 4, read as zero. Writes to them change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| pending_in | input | NUM_SRC | Pending bit per source, from the gateways |
| claim_id_in | input | NUM_CTX*ID_W | Best pending id per context, from the arbiter |
| rsp_valid | output | 1 | Read data valid (cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| src_prio_flat | output | NUM_SRC*PRIO_W | Stored priority per source |
| ctx_thresh_flat | output | NUM_CTX*PRIO_W | Stored threshold per context |
| ctx_enable_flat | output | NUM_CTX*NUM_SRC | Enable bit, index ctx*NUM_SRC+source |
| claim_stb | output | NUM_CTX | One-cycle claim pulse per context |
| complete_stb | output | NUM_CTX | One-cycle complete pulse per context |
| complete_id | output | ID_W | Id carried with a complete pulse |

## Verification
The bench drives two instances from one request stream. Both have 40 sources, two contexts, an enable stride of 0x80 and a context stride of 0x1000; one uses MAX_PRIO = 7 (modulo filtering) and the other MAX_PRIO = 5 (range-checked filtering). The same write therefore reaches both legal-value variants, and the bench can compare a wrapped value against a dropped one. Forty sources leave the last bitmap word partly filled, so the masking of absent source bits can be observed, and the enable slot holds unused word positions past the second word. With two contexts, the bench can check that strobes and thresholds land only in the addressed slot.

// File: rtl/irqc_regs_pkg.sv
package irqc_regs_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } region_e;

  // True when addr falls inside [base, base+span)
  function automatic logic in_window(logic [31:0] addr, logic [31:0] base, logic [31:0] span);
    return (addr >= base) && ((addr - base) < span);
  endfunction

  // Power-of-two test on the count of legal priority values
  function automatic logic prio_wraps(logic [31:0] max_prio);
    return ((max_prio + 32'd1) & max_prio) == 32'd0;
  endfunction

  // Legal stored value for a written word
  function automatic logic [31:0] prio_fold(logic [31:0] v, logic [31:0] max_prio);
    return prio_wraps(max_prio) ? (v & max_prio) : v;
  endfunction

  // Whether the write is kept at all
  function automatic logic prio_keep(logic [31:0] v, logic [31:0] max_prio);
    return prio_wraps(max_prio) ? 1'b1 : (v <= max_prio);
  endfunction

  // Valid-bit mask of bitmap word w for n sources
  function automatic logic [31:0] word_mask(int unsigned w, int unsigned n);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = ((w * 32 + b) < n);
    return m;
  endfunction

  function automatic int unsigned ilog2(int unsigned v);
    int unsigned r;
    r = 0;
    for (int unsigned x = v; x > 1; x = x >> 1) r++;
    return r;
  endfunction

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irqc_addr_decode.sv
module irqc_addr_decode
  import irqc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned NUM_SRC    = 40,
  parameter int unsigned NUM_CTX    = 2,
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h0400,
  parameter int unsigned EN_BASE    = 32'h0800,
  parameter int unsigned EN_STRIDE  = 32'h0080,
  parameter int unsigned CTX_BASE   = 32'h4000,
  parameter int unsigned CTX_STRIDE = 32'h1000,
  localparam int unsigned WORDS     = (NUM_SRC + 31) / 32,
  localparam int unsigned SRC_IW    = idx_w(NUM_SRC),
  localparam int unsigned WORD_IW   = idx_w(WORDS),
  localparam int unsigned CTX_IW    = idx_w(NUM_CTX)
) (
  input  logic [ADDR_W-1:0]  addr,
  output region_e            region,
  output logic [SRC_IW-1:0]  src_idx,
  output logic [WORD_IW-1:0] word_idx,
  output logic [CTX_IW-1:0]  ctx_idx
);

  localparam logic [31:0] PRIO_SPAN = 32'(NUM_SRC * 4);
  localparam logic [31:0] PEND_SPAN = 32'((NUM_SRC + 31) >> 3);
  localparam logic [31:0] EN_SPAN   = 32'(NUM_CTX * EN_STRIDE);
  localparam logic [31:0] CTX_SPAN  = 32'(NUM_CTX * CTX_STRIDE);
  localparam int unsigned EN_SH     = ilog2(EN_STRIDE);
  localparam int unsigned CTX_SH    = ilog2(CTX_STRIDE);

  logic [31:0] a;
  logic [31:0] off;
  logic [31:0] slot_off;

  assign a = 32'(addr);

  always_comb begin
    region   = RG_NONE;
    src_idx  = '0;
    word_idx = '0;
    ctx_idx  = '0;
    off      = '0;
    slot_off = '0;
    if (in_window(a, 32'(PRIO_BASE), PRIO_SPAN)) begin
      off     = a - 32'(PRIO_BASE);
      region  = RG_PRIO;
      src_idx = SRC_IW'(off >> 2);
    end else if (in_window(a, 32'(PEND_BASE), PEND_SPAN)) begin
      off      = a - 32'(PEND_BASE);
      region   = RG_PEND;
      word_idx = WORD_IW'(off >> 2);
    end else if (in_window(a, 32'(EN_BASE), EN_SPAN)) begin
      off      = a - 32'(EN_BASE);
      slot_off = (off & (32'(EN_STRIDE) - 32'd1)) >> 2;
      ctx_idx  = CTX_IW'(off >> EN_SH);
      if (slot_off < 32'(WORDS)) begin
        region   = RG_EN;
        word_idx = WORD_IW'(slot_off);
      end
    end else if (in_window(a, 32'(CTX_BASE), CTX_SPAN)) begin
      off      = a - 32'(CTX_BASE);
      slot_off = off & (32'(CTX_STRIDE) - 32'd1);
      ctx_idx  = CTX_IW'(off >> CTX_SH);
      if (slot_off == 32'd0)      region = RG_THR;
      else if (slot_off == 32'd4) region = RG_CLAIM;
    end
  end

endmodule

// File: rtl/irqc_legal_filter.sv
module irqc_legal_filter
  import irqc_regs_pkg::*;
#(
  parameter int unsigned MAX_PRIO = 7,
  localparam int unsigned PRIO_W  = idx_w(MAX_PRIO + 1)
) (
  input  logic [31:0]       wdata,
  output logic              accept,
  output logic [PRIO_W-1:0] value
);

  generate
    if (prio_wraps(32'(MAX_PRIO))) begin : g_wrap
      // Legal count is a power of two: keep the low bits
      assign accept = 1'b1;
      assign value  = PRIO_W'(prio_fold(wdata, 32'(MAX_PRIO)));
    end else begin : g_range
      // Otherwise reject anything above the maximum
      assign accept = prio_keep(wdata, 32'(MAX_PRIO));
      assign value  = PRIO_W'(wdata);
    end
  endgenerate

endmodule

// File: rtl/irqc_ctx_strobes.sv
module irqc_ctx_strobes
  import irqc_regs_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned NUM_CTX = 2,
  localparam int unsigned CTX_IW = idx_w(NUM_CTX),
  localparam int unsigned ID_W   = idx_w(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               claim_req,
  input  logic               complete_req,
  input  logic [CTX_IW-1:0]  ctx_idx,
  input  logic [31:0]        wdata,
  output logic [NUM_CTX-1:0] claim_stb,
  output logic [NUM_CTX-1:0] complete_stb,
  output logic [ID_W-1:0]    complete_id
);

  logic id_ok;
  assign id_ok = wdata < 32'(NUM_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_stb    <= '0;
      complete_stb <= '0;
      complete_id  <= '0;
    end else begin
      for (int c = 0; c < NUM_CTX; c++) begin
        claim_stb[c]    <= claim_req && (ctx_idx == CTX_IW'(c));
        complete_stb[c] <= complete_req && id_ok && (ctx_idx == CTX_IW'(c));
      end
      if (complete_req && id_ok) complete_id <= ID_W'(wdata);
    end
  end

endmodule

// File: rtl/irqc_reg_frontend.sv
module irqc_reg_frontend
  import irqc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned NUM_SRC    = 40,
  parameter int unsigned NUM_CTX    = 2,
  parameter int unsigned MAX_PRIO   = 7,
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h0400,
  parameter int unsigned EN_BASE    = 32'h0800,
  parameter int unsigned EN_STRIDE  = 32'h0080,
  parameter int unsigned CTX_BASE   = 32'h4000,
  parameter int unsigned CTX_STRIDE = 32'h1000,
  localparam int unsigned PRIO_W    = idx_w(MAX_PRIO + 1),
  localparam int unsigned ID_W      = idx_w(NUM_SRC),
  localparam int unsigned WORDS     = (NUM_SRC + 31) / 32,
  localparam int unsigned SRC_IW    = idx_w(NUM_SRC),
  localparam int unsigned WORD_IW   = idx_w(WORDS),
  localparam int unsigned CTX_IW    = idx_w(NUM_CTX)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [31:0]                 req_wdata,
  input  logic [NUM_SRC-1:0]          pending_in,
  input  logic [NUM_CTX*ID_W-1:0]     claim_id_in,
  output logic                        rsp_valid,
  output logic [31:0]                 rsp_rdata,
  output logic [NUM_SRC*PRIO_W-1:0]   src_prio_flat,
  output logic [NUM_CTX*PRIO_W-1:0]   ctx_thresh_flat,
  output logic [NUM_CTX*NUM_SRC-1:0]  ctx_enable_flat,
  output logic [NUM_CTX-1:0]          claim_stb,
  output logic [NUM_CTX-1:0]          complete_stb,
  output logic [ID_W-1:0]             complete_id
);

  // Decoded request
  region_e            region;
  logic [SRC_IW-1:0]  src_idx;
  logic [WORD_IW-1:0] word_idx;
  logic [CTX_IW-1:0]  ctx_idx;

  irqc_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE),
    .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_decode (
    .addr(req_addr), .region(region), .src_idx(src_idx),
    .word_idx(word_idx), .ctx_idx(ctx_idx)
  );

  // Named internal events
  logic rd_req, wr_req;
  logic wr_prio_hit, wr_thr_hit, wr_en_hit;
  logic claim_fire, complete_fire;
  assign rd_req        = req_valid && !req_write;
  assign wr_req        = req_valid && req_write;
  assign wr_prio_hit   = wr_req && (region == RG_PRIO);
  assign wr_thr_hit    = wr_req && (region == RG_THR);
  assign wr_en_hit     = wr_req && (region == RG_EN);
  assign claim_fire    = rd_req && (region == RG_CLAIM);
  assign complete_fire = wr_req && (region == RG_CLAIM);

  // Legal-value filter shared by priority and threshold writes
  logic              filt_accept;
  logic [PRIO_W-1:0] filt_value;

  irqc_legal_filter #(.MAX_PRIO(MAX_PRIO)) u_filter (
    .wdata(req_wdata), .accept(filt_accept), .value(filt_value)
  );

  // Priority registers
  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prio_q[s] <= '0;
        else if (wr_prio_hit && filt_accept && (src_idx == SRC_IW'(s)))
          prio_q[s] <= filt_value;
      end
      assign src_prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
    end
  endgenerate

  // Threshold registers and enable bitmaps per context
  logic [PRIO_W-1:0]   thr_q  [NUM_CTX];
  logic [WORDS*32-1:0] en_cat [NUM_CTX];
  generate
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q[c] <= '0;
        else if (wr_thr_hit && filt_accept && (ctx_idx == CTX_IW'(c)))
          thr_q[c] <= filt_value;
      end
      assign ctx_thresh_flat[c*PRIO_W +: PRIO_W] = thr_q[c];

      for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [31:0] LIVE = word_mask(w, NUM_SRC);
        logic [31:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) word_q <= '0;
          else if (wr_en_hit && (ctx_idx == CTX_IW'(c)) && (word_idx == WORD_IW'(w)))
            word_q <= req_wdata & LIVE;
        end
        assign en_cat[c][w*32 +: 32] = word_q;
      end
      assign ctx_enable_flat[c*NUM_SRC +: NUM_SRC] = en_cat[c][NUM_SRC-1:0];
    end
  endgenerate

  // Claim / complete strobes
  irqc_ctx_strobes #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_strobes (
    .clk(clk), .rst_n(rst_n), .claim_req(claim_fire), .complete_req(complete_fire),
    .ctx_idx(ctx_idx), .wdata(req_wdata), .claim_stb(claim_stb),
    .complete_stb(complete_stb), .complete_id(complete_id)
  );

  // Read multiplexer
  logic [WORDS*32-1:0] pend_pad;
  logic [31:0]         rd_value;
  assign pend_pad = (WORDS*32)'(pending_in);

  always_comb begin
    rd_value = '0;
    unique case (region)
      RG_PRIO: begin
        for (int s = 0; s < NUM_SRC; s++)
          if (src_idx == SRC_IW'(s)) rd_value = 32'(prio_q[s]);
      end
      RG_PEND: begin
        for (int w = 0; w < WORDS; w++)
          if (word_idx == WORD_IW'(w)) rd_value = pend_pad[w*32 +: 32];
      end
      RG_EN: begin
        for (int c = 0; c < NUM_CTX; c++)
          for (int w = 0; w < WORDS; w++)
            if (ctx_idx == CTX_IW'(c) && word_idx == WORD_IW'(w))
              rd_value = en_cat[c][w*32 +: 32];
      end
      RG_THR: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (ctx_idx == CTX_IW'(c)) rd_value = 32'(thr_q[c]);
      end
      RG_CLAIM: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (ctx_idx == CTX_IW'(c)) rd_value = 32'(claim_id_in[c*ID_W +: ID_W]);
      end
      default: rd_value = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_value : 32'd0;
    end
  end

endmodule

// File: rtl/irqc_reg_frontend_chk.sv
module irqc_reg_frontend_chk
  import irqc_regs_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 40,
  parameter int unsigned NUM_CTX  = 2,
  parameter int unsigned MAX_PRIO = 7,
  localparam int unsigned PRIO_W  = idx_w(MAX_PRIO + 1),
  localparam int unsigned ID_W    = idx_w(NUM_SRC)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_write,
  input logic [31:0]                req_wdata,
  input logic                       rsp_valid,
  input logic [NUM_SRC*PRIO_W-1:0]  src_prio_flat,
  input logic [NUM_CTX*PRIO_W-1:0]  ctx_thresh_flat,
  input logic [NUM_CTX*NUM_SRC-1:0] ctx_enable_flat,
  input logic [NUM_CTX-1:0]         claim_stb,
  input logic [NUM_CTX-1:0]         complete_stb,
  input logic [ID_W-1:0]            complete_id
);

  assert_rsp_only_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_read_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_claim_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_stb));

  assert_claim_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|claim_stb) |-> $past(req_valid && !req_write));

  assert_complete_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(complete_stb));

  assert_complete_carries_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|complete_stb) |-> ($past(req_valid && req_write) &&
                         (32'(complete_id) < 32'(NUM_SRC)) &&
                         (complete_id == $past(req_wdata[ID_W-1:0]))));

  assert_state_held_without_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_write) |->
      ($stable(src_prio_flat) && $stable(ctx_thresh_flat) && $stable(ctx_enable_flat)));

  generate
    if (!prio_wraps(32'(MAX_PRIO))) begin : g_range_chk
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assert_prio_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
          32'(src_prio_flat[s*PRIO_W +: PRIO_W]) <= 32'(MAX_PRIO));
      end
      for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        assert_thr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
          32'(ctx_thresh_flat[c*PRIO_W +: PRIO_W]) <= 32'(MAX_PRIO));
      end
    end
  endgenerate

endmodule

bind irqc_reg_frontend irqc_reg_frontend_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .MAX_PRIO(MAX_PRIO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .src_prio_flat(src_prio_flat),
  .ctx_thresh_flat(ctx_thresh_flat), .ctx_enable_flat(ctx_enable_flat),
  .claim_stb(claim_stb), .complete_stb(complete_stb), .complete_id(complete_id)
);

// File: tb/irqc_reg_frontend_tb.sv
`timescale 1ns/1ps
module irqc_reg_frontend_tb;

  localparam int NS = 40;
  localparam int NC = 2;
  localparam int PW = 3;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [15:0]       req_addr  = '0;
  logic [31:0]       req_wdata = '0;
  logic [NS-1:0]     pending_in = '0;
  logic [NC*IW-1:0]  claim_id_in = '0;

  logic              vld_a, vld_b;
  logic [31:0]       dat_a, dat_b;
  logic [NS*PW-1:0]  prio_a, prio_b;
  logic [NC*PW-1:0]  thr_a, thr_b;
  logic [NC*NS-1:0]  en_a, en_b;
  logic [NC-1:0]     clm_a, clm_b, cmp_a, cmp_b;
  logic [IW-1:0]     cid_a, cid_b;

  // Wrapping variant (MAX_PRIO = 7)
  irqc_reg_frontend #(.MAX_PRIO(7)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .pending_in(pending_in),
    .claim_id_in(claim_id_in), .rsp_valid(vld_a), .rsp_rdata(dat_a),
    .src_prio_flat(prio_a), .ctx_thresh_flat(thr_a), .ctx_enable_flat(en_a),
    .claim_stb(clm_a), .complete_stb(cmp_a), .complete_id(cid_a)
  );

  // Range-checked variant (MAX_PRIO = 5)
  irqc_reg_frontend #(.MAX_PRIO(5)) u_dut_rng (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .pending_in(pending_in),
    .claim_id_in(claim_id_in), .rsp_valid(vld_b), .rsp_rdata(dat_b),
    .src_prio_flat(prio_b), .ctx_thresh_flat(thr_b), .ctx_enable_flat(en_b),
    .claim_stb(clm_b), .complete_stb(cmp_b), .complete_id(cid_b)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One request; returns after the response cycle, sampled at negedge
  task automatic access(bit wr, logic [15:0] addr, logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  function automatic logic [PW-1:0] pr(logic [NS*PW-1:0] f, int s);
    return f[s*PW +: PW];
  endfunction

  task automatic t_reset;
    chk("R1 prio a", 64'(prio_a), 0);
    chk("R1 prio b", 64'(prio_b), 0);
    chk("R1 thr", 64'({thr_a, thr_b}), 0);
    chk("R1 enable", 64'(en_a), 0);
    chk("R1 strobes", 64'({clm_a, cmp_a, clm_b, cmp_b}), 0);
    chk("R1 rsp", 64'({vld_a, dat_a}), 0);
  endtask

  task automatic t_priority;
    // R3: source 3 at 0x0C
    access(1, 16'h000C, 32'd5);
    chk("R2 no rsp on write", 64'(vld_a), 0);
    chk("R3 src3 a", 64'(pr(prio_a, 3)), 5);
    chk("R5 src3 b in range", 64'(pr(prio_b, 3)), 5);
    access(1, 16'h000C, 32'd6);
    chk("R4 src3 a", 64'(pr(prio_a, 3)), 6);
    chk("R5 src3 b dropped", 64'(pr(prio_b, 3)), 5);
    // R4: 19 mod 8 = 3 at source 0
    access(1, 16'h0000, 32'd19);
    chk("R4 src0 wrap", 64'(pr(prio_a, 0)), 3);
    chk("R5 src0 dropped", 64'(pr(prio_b, 0)), 0);
    // last source 39 at 0x9C
    access(1, 16'h009C, 32'hF);
    access(0, 16'h009C, 32'd0);
    chk("R2 rsp valid", 64'(vld_a), 1);
    chk("R3 read src39 a", 64'(dat_a), 7);
    chk("R3 read src39 b", 64'(dat_b), 0);
    access(0, 16'h000C, 32'd0);
    chk("R3 read src3 b", 64'(dat_b), 5);
    chk("R3 neighbours untouched", 64'({pr(prio_a, 2), pr(prio_a, 4)}), 0);
  endtask

  task automatic t_pending;
    pending_in = 40'hA5_1234_5678;
    access(0, 16'h0400, 32'd0);
    chk("R6 word0", 64'(dat_a), 64'h1234_5678);
    access(0, 16'h0404, 32'd0);
    chk("R6 word1", 64'(dat_a), 64'hA5);
    access(1, 16'h0400, 32'hFFFF_FFFF);
    access(0, 16'h0400, 32'd0);
    chk("R6 write ignored", 64'(dat_a), 64'h1234_5678);
    chk("R6 no state change", 64'(en_a), 0);
  endtask

  task automatic t_enable;
    access(1, 16'h0800, 32'hDEAD_BEEF);
    chk("R7 ctx0 word0", 64'(en_a[31:0]), 64'hDEAD_BEEF);
    chk("R7 ctx1 untouched", 64'(en_a[79:40]), 0);
    access(1, 16'h0884, 32'hFFFF_FFFF);
    chk("R7 ctx1 word1 bits", 64'(en_a[79:72]), 64'hFF);
    access(0, 16'h0884, 32'd0);
    chk("R7 absent bits read zero", 64'(dat_a), 64'hFF);
    access(1, 16'h0808, 32'h1234);
    chk("R8 write beyond words", 64'(en_a), {24'd0, 8'hFF, 32'd0, 8'd0, 32'hDEAD_BEEF});
    access(0, 16'h0808, 32'd0);
    chk("R8 read beyond words", 64'(dat_a), 0);
  endtask

  task automatic t_threshold;
    access(1, 16'h4000, 32'd9);
    chk("R9 R4 ctx0 thr a", 64'(thr_a), 64'd1);
    chk("R9 R5 ctx0 thr b dropped", 64'(thr_b), 0);
    access(1, 16'h5000, 32'd4);
    chk("R9 ctx1 thr a", 64'(thr_a[5:3]), 4);
    chk("R9 ctx1 thr b", 64'(thr_b), 64'({3'd4, 3'd0}));
    access(0, 16'h5000, 32'd0);
    chk("R9 read ctx1 thr", 64'(dat_b), 4);
  endtask

  task automatic t_claim_complete;
    claim_id_in = {6'd17, 6'd33};
    access(0, 16'h5004, 32'd0);
    chk("R10 claim data ctx1", 64'(dat_a), 17);
    chk("R10 claim strobe ctx1", 64'(clm_a), 64'b10);
    @(negedge clk);
    chk("R10 claim one cycle", 64'(clm_a), 0);
    access(0, 16'h4004, 32'd0);
    chk("R10 claim data ctx0", 64'({clm_a, dat_a}), {2'b01, 32'd33});
    access(1, 16'h4004, 32'd12);
    chk("R11 complete ctx0", 64'({cmp_a, cid_a}), {2'b01, 6'd12});
    chk("R11 no claim on write", 64'(clm_a), 0);
    access(1, 16'h5004, 32'd39);
    chk("R11 complete ctx1 max id", 64'({cmp_b, cid_b}), {2'b10, 6'd39});
    access(1, 16'h4004, 32'd40);
    chk("R11 id out of range", 64'(cmp_a), 0);
  endtask

  task automatic t_unmapped;
    logic [NS*PW-1:0] p0;
    logic [NC*NS-1:0] e0;
    logic [NC*PW-1:0] t0;
    p0 = prio_a; e0 = en_a; t0 = thr_a;
    access(0, 16'h00A0, 32'd0);
    chk("R12 past prio window", 64'({vld_a, dat_a}), {1'b1, 32'd0});
    access(0, 16'h0408, 32'd0);
    chk("R12 past pending window", 64'(dat_a), 0);
    access(0, 16'h4008, 32'd0);
    chk("R12 ctx offset 8", 64'({clm_a, dat_a}), 0);
    access(1, 16'h00A0, 32'd7);
    access(1, 16'h3000, 32'hFFFF_FFFF);
    access(1, 16'h4008, 32'd3);
    chk("R12 prio unchanged", 64'(p0 == prio_a), 1);
    chk("R12 en/thr unchanged", 64'((e0 == en_a) && (t0 == thr_a)), 1);
    chk("R12 no strobe", 64'({cmp_a, clm_a}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_priority;
    t_pending;
    t_enable;
    t_threshold;
    t_claim_complete;
    t_unmapped;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule